// File: doc/BRIEF.md
# Accumulator Multicycle Stored-Program Processor

This block is a small processor with a single accumulator. It keeps its program and its data in one external memory and reaches that memory through one synchronous port. Every memory access uses an address register and a data register. The processor moves through distinct phases: it reads an instruction word into the data register, copies it into the instruction register, advances the program counter, decodes the opcode, and then runs a load, add or store against a directly addressed memory word.

The block is meant to sit beside a synchronous single-port RAM. The RAM returns read data one clock after the read strobe. Instruction words are 16 bits wide. Bits [15:12] hold the opcode and bits [11:0] hold a direct word address. After reset the processor starts fetching at address 0. It runs until it decodes a halt instruction, and then it stays idle until the next reset.

Top module: `accum_cpu`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `mem_rd`, `mem_wr` and `halted` are 0 and `mem_addr` is 0. The first read strobe after reset is issued at address 0.
- R2: Each instruction fetch reads the address held in the program counter. The program counter then advances by one, so that successive instructions are fetched from consecutive addresses.
- R3: Instruction word encoding: opcode in bits [15:12] and operand address in bits [11:0]. Opcode 0 is halt, 1 is load, 2 is add and 3 is store. Code and data share one memory, so a word that a store writes is executed if it is later fetched.
- R4: Load (opcode 1) reads the word at its operand address and places it in the accumulator.
- R5: Add (opcode 2) reads the word at its operand address and adds it to the accumulator modulo 2^16. No flags are produced.
- R6: Store (opcode 3) pulses `mem_wr` for one cycle with `mem_addr` equal to the operand address and `mem_wdata` equal to the accumulator.
- R7: Halt (opcode 0) raises `halted`. `halted` stays high and no read or write strobe is issued until `rst` is asserted, and reset clears `halted`.
- R8: Opcodes 4 to 15 perform no operation. They cause no memory access other than their own fetch and leave the accumulator unchanged.
- R9: Timing. Read data is taken one cycle after the read strobe. An operand read comes 4 cycles after its fetch read. Load and add take 8 cycles from fetch to the next fetch, store takes 7 cycles, and a no-operation takes 5 cycles. The write strobe comes 5 cycles after the store's fetch read.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle, and each read strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address, driven from the address register |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| mem_rd | output | 1 | Read strobe, one cycle wide |
| mem_wr | output | 1 | Write strobe, one cycle wide |
| halted | output | 1 | Sticky halt indication |

## Verification
The assertions assume that `mem_rdata` holds the word addressed in the cycle that follows a read strobe, exactly as a one-cycle synchronous RAM returns it. They place no other condition on the data values. The bench models such a RAM and changes its contents only while `rst` is high, so every fetched and operand word matches what the bench expects. The programs stay within the low 256 words of the memory model, and only defined opcodes and a few chosen undefined ones are used, so each expected result and access stamp is known in advance.

// File: rtl/accum_pkg.sv
package accum_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_HLT = 4'd0,
    OP_LDA = 4'd1,
    OP_ADD = 4'd2,
    OP_STA = 4'd3
  } opcode_e;

  typedef enum logic [3:0] {
    ST_FMAR,   // address register <- program counter
    ST_RD,     // read strobe on the bus
    ST_WAIT,   // returned word -> data register
    ST_CIR,    // instruction register <- data register, PC + 1
    ST_DEC,    // decode
    ST_OPR,    // accumulator update from data register
    ST_SMAR,   // address register <- operand for store
    ST_WR,     // write strobe on the bus
    ST_HALT
  } state_e;

  typedef enum logic [1:0] {
    ACC_HOLD,
    ACC_LOAD,
    ACC_ADD
  } acc_op_e;

  typedef struct packed {
    logic    mar_from_pc;
    logic    mar_from_ir;
    logic    mdr_from_mem;
    logic    mdr_from_acc;
    logic    cir_from_mdr;
    logic    pc_inc;
    acc_op_e acc_op;
  } ctl_s;

endpackage

// File: rtl/accum_alu.sv
module accum_alu
  import accum_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  acc_op_e             op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output logic [DATA_W-1:0]   y
);

  always_comb begin
    case (op)
      ACC_LOAD: y = b;
      ACC_ADD:  y = a + b;   // wraps, no flags
      default:  y = a;
    endcase
  end

endmodule

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output ctl_s             ctl,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             halted
);

  state_e state, nxt;
  logic   fetch_ph;
  logic   rd_q, wr_q, halt_q;

  always_comb begin
    nxt = state;
    ctl = '0;
    case (state)
      ST_FMAR: begin
        ctl.mar_from_pc = 1'b1;
        nxt = ST_RD;
      end
      ST_RD:   nxt = ST_WAIT;
      ST_WAIT: begin
        ctl.mdr_from_mem = 1'b1;
        nxt = fetch_ph ? ST_CIR : ST_OPR;
      end
      ST_CIR: begin
        ctl.cir_from_mdr = 1'b1;
        ctl.pc_inc       = 1'b1;
        nxt = ST_DEC;
      end
      ST_DEC: begin
        case (opcode)
          OP_LDA, OP_ADD: begin
            ctl.mar_from_ir = 1'b1;
            nxt = ST_RD;
          end
          OP_STA: begin
            ctl.mdr_from_acc = 1'b1;
            nxt = ST_SMAR;
          end
          OP_HLT:  nxt = ST_HALT;
          default: nxt = ST_FMAR;
        endcase
      end
      ST_OPR: begin
        ctl.acc_op = (opcode == OP_ADD) ? ACC_ADD : ACC_LOAD;
        nxt = ST_FMAR;
      end
      ST_SMAR: begin
        ctl.mar_from_ir = 1'b1;
        nxt = ST_WR;
      end
      ST_WR:   nxt = ST_FMAR;
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_FMAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FMAR;
      fetch_ph <= 1'b1;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      halt_q   <= 1'b0;
    end else begin
      state  <= nxt;
      rd_q   <= (nxt == ST_RD);
      wr_q   <= (nxt == ST_WR);
      halt_q <= halt_q | (nxt == ST_HALT);
      if (state == ST_FMAR)     fetch_ph <= 1'b1;
      else if (state == ST_DEC) fetch_ph <= 1'b0;
    end
  end

  assign mem_rd = rd_q;
  assign mem_wr = wr_q;
  assign halted = halt_q;

  // R10: one access per cycle, read pulse one cycle wide
  a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !(rd_q && wr_q));
  a_r10_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_q |=> !rd_q);
  // R9: data register captures in the cycle after the read strobe
  a_r9_capture_after_rd: assert property (@(posedge clk) disable iff (rst)
    rd_q |=> ctl.mdr_from_mem);
  // R7: halt is sticky and silences the bus
  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> halt_q);
  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halt_q |-> (!rd_q && !wr_q));

endmodule

// File: rtl/accum_datapath.sv
module accum_datapath
  import accum_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_s              ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [OPC_W-1:0]  opcode
);

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mdr, cir, acc, alu_y;

  accum_alu #(.DATA_W(DATA_W)) alu_i (
    .op (ctl.acc_op),
    .a  (acc),
    .b  (mdr),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      cir <= '0;
      acc <= '0;
    end else begin
      if (ctl.mar_from_pc)       mar <= pc;
      else if (ctl.mar_from_ir)  mar <= cir[ADDR_W-1:0];
      if (ctl.mdr_from_mem)      mdr <= mem_rdata;
      else if (ctl.mdr_from_acc) mdr <= acc;
      if (ctl.cir_from_mdr)      cir <= mdr;
      if (ctl.pc_inc)            pc  <= pc + 1'b1;
      if (ctl.acc_op != ACC_HOLD) acc <= alu_y;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign opcode    = cir[DATA_W-1 -: OPC_W];

  // R2: program counter steps by one after each fetch
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    ctl.pc_inc |=> (pc == $past(pc) + 1'b1));
  // R4: load takes the captured word
  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    (ctl.acc_op == ACC_LOAD) |=> (acc == $past(mdr)));
  // R5: add wraps modulo 2^DATA_W
  a_r5_add_wrap: assert property (@(posedge clk) disable iff (rst)
    (ctl.acc_op == ACC_ADD) |=> (acc == $past(acc) + $past(mdr)));
  // R8: accumulator untouched unless an update is commanded
  a_r8_acc_hold: assert property (@(posedge clk) disable iff (rst)
    (ctl.acc_op == ACC_HOLD) |=> $stable(acc));

endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
  import accum_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              halted
);

  ctl_s             ctl;
  logic [OPC_W-1:0] opcode;

  accum_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .ctl    (ctl),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .halted (halted)
  );

  accum_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .opcode    (opcode)
  );

  // R6: write data leaves only on a write strobe, never together with a read
  a_r6_wr_no_rd: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> !mem_rd);

endmodule

// File: tb/accum_cpu_tb_top.sv
module accum_cpu_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_rd, mem_wr, halted;

  always #5 clk = ~clk;

  accum_cpu dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted)
  );

  // memory model and access log
  logic [15:0] mem [256];
  logic        log_clr = 1'b1;
  int          cyc, n_rd, n_wr;
  logic [11:0] rd_addr [64];
  int          rd_cyc  [64];
  logic [11:0] wr_addr [64];
  logic [15:0] wr_data [64];
  int          wr_cyc  [64];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (log_clr) begin
      cyc <= 0; n_rd <= 0; n_wr <= 0;
    end else begin
      cyc <= cyc + 1;
      if (mem_rd && n_rd < 64) begin
        rd_addr[n_rd] <= mem_addr; rd_cyc[n_rd] <= cyc; n_rd <= n_rd + 1;
      end
      if (mem_wr && n_wr < 64) begin
        wr_addr[n_wr] <= mem_addr; wr_data[n_wr] <= mem_wdata;
        wr_cyc[n_wr] <= cyc; n_wr <= n_wr + 1;
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic start();
    @(negedge clk);
    rst = 1'b0; log_clr = 1'b0;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst = 1'b1; log_clr = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_halt();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (halted) break;
    end
  endtask

  // vectors: {operand a, operand b, expected sum}
  localparam logic [15:0] VEC [6][3] = '{
    '{16'd20,   16'd30,   16'd50},
    '{16'hFFFF, 16'h0001, 16'h0000},
    '{16'h8000, 16'h8000, 16'h0000},
    '{16'h1234, 16'h4321, 16'h5555},
    '{16'h0000, 16'h0000, 16'h0000},
    '{16'h7FFF, 16'h0001, 16'h8000}
  };

  task automatic load_add_prog(input logic [15:0] a, input logic [15:0] b);
    clear_mem();
    mem[0] = 16'h1010;  // load  [0x10]
    mem[1] = 16'h2011;  // add   [0x11]
    mem[2] = 16'h3012;  // store [0x12]
    mem[3] = 16'h0000;  // halt
    mem[8'h10] = a;
    mem[8'h11] = b;
    mem[8'h12] = 16'hDEAD;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(mem_rd == 1'b0 && mem_wr == 1'b0, "R1 strobes in reset", {mem_rd, mem_wr}, 0);
    chk(halted == 1'b0, "R1 halted in reset", halted, 0);
    chk(mem_addr == 12'h000, "R1 addr in reset", mem_addr, 0);

    // table walk: R4 R5 R6
    foreach (VEC[v]) begin
      enter_reset();
      load_add_prog(VEC[v][0], VEC[v][1]);
      start();
      wait_halt();
      chk(mem[8'h12] == VEC[v][2], "R5 sum stored", mem[8'h12], VEC[v][2]);
      chk(halted == 1'b1, "R7 halted after program", halted, 1);
    end

    // directed: access order and timing for 20 + 30
    enter_reset();
    load_add_prog(16'd20, 16'd30);
    start();
    chk(mem_rd == 1'b0 && mem_addr == 12'h000, "R1 first cycle after reset", {mem_rd, mem_addr}, 0);
    wait_halt();
    chk(n_rd == 6, "R2 read count", n_rd, 6);
    chk(rd_addr[0] == 12'h000, "R1 first fetch address", rd_addr[0], 0);
    chk(rd_addr[1] == 12'h010, "R4 operand read address", rd_addr[1], 12'h010);
    chk(rd_addr[2] == 12'h001, "R2 second fetch address", rd_addr[2], 1);
    chk(rd_addr[3] == 12'h011, "R5 operand read address", rd_addr[3], 12'h011);
    chk(rd_addr[4] == 12'h002 && rd_addr[5] == 12'h003, "R2 later fetches",
        {rd_addr[4], rd_addr[5]}, 32'h002003);
    chk(rd_cyc[1] - rd_cyc[0] == 4, "R9 fetch to operand read", rd_cyc[1] - rd_cyc[0], 4);
    chk(rd_cyc[2] - rd_cyc[0] == 8, "R9 load period", rd_cyc[2] - rd_cyc[0], 8);
    chk(rd_cyc[4] - rd_cyc[2] == 8, "R9 add period", rd_cyc[4] - rd_cyc[2], 8);
    chk(rd_cyc[5] - rd_cyc[4] == 7, "R9 store period", rd_cyc[5] - rd_cyc[4], 7);
    chk(n_wr == 1, "R6 one write", n_wr, 1);
    chk(wr_addr[0] == 12'h012 && wr_data[0] == 16'd50, "R6 write address and data",
        {wr_addr[0], wr_data[0]}, {12'h012, 16'd50});
    chk(wr_cyc[0] - rd_cyc[4] == 5, "R9 store write timing", wr_cyc[0] - rd_cyc[4], 5);

    // R7: halt is sticky and silent
    begin
      int rd0, wr0;
      rd0 = n_rd; wr0 = n_wr;
      repeat (40) @(negedge clk);
      chk(n_rd == rd0 && n_wr == wr0, "R7 no access while halted", n_rd - rd0 + n_wr - wr0, 0);
      chk(halted == 1'b1, "R7 halt sticky", halted, 1);
    end

    // R8: undefined opcodes are no-ops
    enter_reset();
    chk(halted == 1'b0, "R7 reset clears halt", halted, 0);
    clear_mem();
    mem[0] = 16'h1010; mem[1] = 16'h7055; mem[2] = 16'hF0AA;
    mem[3] = 16'h3012; mem[4] = 16'h0000;
    mem[8'h10] = 16'h00AB; mem[8'h55] = 16'h1111; mem[8'hAA] = 16'h2222;
    start();
    wait_halt();
    chk(n_rd == 6, "R8 no operand access", n_rd, 6);
    chk(rd_addr[3] == 12'h002, "R8 fetch after no-op", rd_addr[3], 2);
    chk(rd_cyc[3] - rd_cyc[2] == 5, "R9 no-op period", rd_cyc[3] - rd_cyc[2], 5);
    chk(mem[8'h12] == 16'h00AB, "R8 accumulator unchanged", mem[8'h12], 16'h00AB);
    chk(mem[8'h55] == 16'h1111 && mem[8'hAA] == 16'h2222, "R8 no write", n_wr, 1);

    // R3: a stored word executes when fetched
    enter_reset();
    clear_mem();
    mem[0] = 16'h1010;  // load word that encodes "store [0x20]"
    mem[1] = 16'h3002;  // store it over address 2
    mem[2] = 16'h0000;  // replaced before fetch
    mem[3] = 16'h0000;
    mem[8'h10] = 16'h3020;
    start();
    wait_halt();
    chk(mem[8'h20] == 16'h3020, "R3 self-written instruction runs", mem[8'h20], 16'h3020);
    chk(n_wr == 2, "R3 two writes", n_wr, 2);

    // R7: halt at address 0 stops everything
    enter_reset();
    clear_mem();
    mem[0] = 16'h0000; mem[1] = 16'h3012;
    start();
    wait_halt();
    repeat (20) @(negedge clk);
    chk(n_rd == 1 && n_wr == 0, "R7 immediate halt", {n_rd[7:0], n_wr[7:0]}, 16'h0100);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule